// File: doc/BRIEF.md
# Multiplexed Segment Display Scan Controller

This block stores the segment image of a multiplexed segment display and presents it one backplane phase at a time. Software-side logic writes and reads the image through a byte-wide register port. A mode input chooses which of two planes the port reaches: the segment on/off plane or the per-segment blink-enable plane. Both planes share one address map.

An external clock divider supplies a frame-phase strobe and a blink-phase level. On every strobe the block registers a one-hot backplane select and the frontplane on/off vector for that phase. An external analog stage turns these into drive voltages. A duty code sets how many backplanes are scanned, either 2, 3 or 4. When all four backplanes are in use, the last frontplane pin is taken over as backplane 3 and its segment output is held off.

Blinking works per segment or for the whole display. While the blink phase is dark, a segment is blanked if its blink-enable bit is set. With the blink-all control active and the port in blink-plane mode, every segment is blanked. Nothing here depends on the host core, so blinking continues as long as the strobes arrive.

Top module: `seg_scan_ctrl`

## Requirements
- R1: Synchronous reset clears both planes and drives `bp_sel`, `fp_on` and `reg_rdata` to zero.
- R2: A write with `plane_sel`=0 stores into the on/off plane. With `plane_sel`=1 it stores into a separate blink-enable plane. `reg_rdata` returns the byte at `reg_addr` in the plane chosen by `plane_sel`, one clock after the address is presented.
- R3: Byte k holds frontplane 2k in bits 3:0 and frontplane 2k+1 in bits 7:4. Within a nibble, bit y is the segment on backplane y. During phase y, `fp_on[f]` equals that bit, subject to R7 to R9.
- R4: The map has 21 bytes (addresses 0 to 20). Byte 20 holds only frontplane 40 in bits 3:0, and bits 7:4 always read 0. Writes to addresses 21 to 31 are ignored, and reads there return 0.
- R5: Each `frame_strobe` while enabled loads `bp_sel` with the one-hot code of the current phase, and the phase then advances. Phases run 0,1,..,D-1 cyclically. `duty_code` 1, 2 and 3 give D = 2, 3 and 4, and code 0 is treated as D = 2. `bp_sel` is never more than one-hot.
- R6: While `disp_en` is 0, `bp_sel` and `fp_on` are 0 from the next clock and the phase is held at 0. The first strobe after enabling shows phase 0.
- R7: With D = 4, `fp_on[40]` is 0. With D = 2 or 3 it follows the stored bit.
- R8: A strobe taken with `blink_dark`=1 drives off every segment whose blink-enable bit is 1. A strobe taken with `blink_dark`=0 shows the on/off plane unchanged.
- R9: A strobe taken with `blink_dark`=1, `blink_all`=1 and `plane_sel`=1 drives all of `fp_on` to 0. `blink_all` has no effect while `plane_sel`=0.
- R10: `fp_on` and `bp_sel` change only on a strobe or on disable. A write between strobes shows up from the next strobe onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 5 | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| plane_sel | input | 1 | 0: on/off plane, 1: blink-enable plane |
| duty_code | input | 2 | Backplane count minus one (0 acts as 1) |
| disp_en | input | 1 | Display enable |
| blink_all | input | 1 | Whole-display blink override |
| frame_strobe | input | 1 | Phase boundary pulse |
| blink_dark | input | 1 | Blink phase, 1 = dark half |
| bp_sel | output | 4 | One-hot backplane select |
| fp_on | output | 41 | Frontplane on/off vector |

## Verification
The bench uses the default parameters: 41 frontplanes and 4 backplanes. With these values it reaches the half-filled last byte, all eleven unmapped addresses and the pin that serves as either frontplane 40 or backplane 3. Both planes are filled with arithmetic patterns and read back in full. Every duty code is swept through two full frames, and each frontplane of every phase is compared with a value the bench computes from its own copy of the image under each combination of the blink controls.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

  typedef enum logic {
    PLANE_ONOFF = 1'b0,
    PLANE_BLINK = 1'b1
  } plane_e;

  // Index of the last scanned backplane for a duty code; code 0 maps to 1.
  function automatic int unsigned last_phase(int unsigned code, int unsigned nbp);
    if (code == 0) return 1;
    if (code > nbp - 1) return nbp - 1;
    return code;
  endfunction

endpackage

// File: rtl/seg_scan_mem.sv
module seg_scan_mem
  import seg_scan_pkg::*;
#(
  parameter  int NUM_FP = 41,
  parameter  int NUM_BP = 4,
  localparam int BYTE_W = 2 * NUM_BP,
  localparam int NBYTES = (NUM_FP + 1) / 2,
  localparam int ADDR_W = $clog2(NBYTES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [BYTE_W-1:0]          wdata,
  input  logic                       plane_sel,
  output logic [BYTE_W-1:0]          rdata,
  output logic [NBYTES*BYTE_W-1:0]   on_flat,
  output logic [NBYTES*BYTE_W-1:0]   bl_flat
);

  // An odd frontplane count leaves the top nibble of the last byte unmapped.
  localparam logic [BYTE_W-1:0] LAST_MASK = {BYTE_W{1'b1}} >> ((NUM_FP % 2) * NUM_BP);

  logic [BYTE_W-1:0] on_mem [NBYTES];
  logic [BYTE_W-1:0] bl_mem [NBYTES];
  logic              in_range;
  logic [BYTE_W-1:0] wmask;
  plane_e            plane;

  assign in_range = (addr < ADDR_W'(NBYTES));
  assign wmask    = (addr == ADDR_W'(NBYTES - 1)) ? LAST_MASK : {BYTE_W{1'b1}};
  assign plane    = plane_e'(plane_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBYTES; i++) begin
        on_mem[i] <= '0;
        bl_mem[i] <= '0;
      end
      rdata <= '0;
    end else begin
      if (we && in_range) begin
        if (plane == PLANE_BLINK) bl_mem[addr] <= wdata & wmask;
        else                      on_mem[addr] <= wdata & wmask;
      end
      if (!in_range)                 rdata <= '0;
      else if (plane == PLANE_BLINK) rdata <= bl_mem[addr];
      else                           rdata <= on_mem[addr];
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_flat
    assign on_flat[b*BYTE_W +: BYTE_W] = on_mem[b];
    assign bl_flat[b*BYTE_W +: BYTE_W] = bl_mem[b];
  end

  // R4: unmapped addresses read as zero
  assert_unmapped_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (addr >= ADDR_W'(NBYTES)) |=> (rdata == '0));

endmodule

// File: rtl/seg_scan_phase.sv
module seg_scan_phase
  import seg_scan_pkg::*;
#(
  parameter  int NUM_BP = 4,
  localparam int BP_W   = $clog2(NUM_BP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              disp_en,
  input  logic              frame_strobe,
  input  logic [BP_W-1:0]   duty_code,
  output logic [BP_W-1:0]   cur_phase,
  output logic              full_duty,
  output logic [NUM_BP-1:0] bp_sel
);

  logic [BP_W-1:0] idx;
  logic [BP_W-1:0] last;

  assign last      = BP_W'(last_phase(32'(duty_code), NUM_BP));
  assign cur_phase = (idx > last) ? '0 : idx;
  assign full_duty = (last == BP_W'(NUM_BP - 1));

  always_ff @(posedge clk) begin
    if (rst || !disp_en) begin
      idx    <= '0;
      bp_sel <= '0;
    end else if (frame_strobe) begin
      bp_sel <= NUM_BP'(1) << cur_phase;
      idx    <= (cur_phase == last) ? '0 : cur_phase + 1'b1;
    end
  end

  // R5: never more than one backplane selected
  assert_bp_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bp_sel));

  // R6: disable blanks the backplanes on the next clock
  assert_idle_blank_R6: assert property (@(posedge clk) disable iff (rst)
    !disp_en |=> (bp_sel == '0));

  // R6: first strobe after enabling selects backplane 0
  assert_restart_phase0_R6: assert property (@(posedge clk) disable iff (rst)
    (disp_en && frame_strobe && !$past(disp_en)) |=> (bp_sel == NUM_BP'(1)));

endmodule

// File: rtl/seg_scan_column.sv
module seg_scan_column #(
  parameter  int NUM_FP = 41,
  parameter  int NUM_BP = 4,
  localparam int BYTE_W = 2 * NUM_BP,
  localparam int NBYTES = (NUM_FP + 1) / 2,
  localparam int BP_W   = $clog2(NUM_BP)
) (
  input  logic [NBYTES*BYTE_W-1:0] on_flat,
  input  logic [NBYTES*BYTE_W-1:0] bl_flat,
  input  logic [BP_W-1:0]          phase,
  input  logic                     blank_en,
  input  logic                     force_all,
  input  logic                     full_duty,
  output logic [NUM_FP-1:0]        column
);

  for (genvar f = 0; f < NUM_FP; f++) begin : g_fp
    localparam int BASE = (f / 2) * BYTE_W + (f % 2) * NUM_BP;
    logic [NUM_BP-1:0] on_nib;
    logic [NUM_BP-1:0] bl_nib;
    logic              lit;

    assign on_nib = on_flat[BASE +: NUM_BP];
    assign bl_nib = bl_flat[BASE +: NUM_BP];
    assign lit    = on_nib[phase] & ~(blank_en & (bl_nib[phase] | force_all));

    if (f == NUM_FP - 1) begin : g_shared
      // This pin becomes the last backplane when every backplane is scanned.
      assign column[f] = lit & ~full_duty;
    end else begin : g_plain
      assign column[f] = lit;
    end
  end

endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl #(
  parameter  int NUM_FP = 41,
  parameter  int NUM_BP = 4,
  localparam int BYTE_W = 2 * NUM_BP,
  localparam int NBYTES = (NUM_FP + 1) / 2,
  localparam int ADDR_W = $clog2(NBYTES),
  localparam int BP_W   = $clog2(NUM_BP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              plane_sel,
  input  logic [BP_W-1:0]   duty_code,
  input  logic              disp_en,
  input  logic              blink_all,
  input  logic              frame_strobe,
  input  logic              blink_dark,
  output logic [NUM_BP-1:0] bp_sel,
  output logic [NUM_FP-1:0] fp_on
);

  logic [NBYTES*BYTE_W-1:0] on_flat;
  logic [NBYTES*BYTE_W-1:0] bl_flat;
  logic [BP_W-1:0]          cur_phase;
  logic                     full_duty;
  logic [NUM_FP-1:0]        column;

  seg_scan_mem #(.NUM_FP(NUM_FP), .NUM_BP(NUM_BP)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .plane_sel (plane_sel),
    .rdata     (reg_rdata),
    .on_flat   (on_flat),
    .bl_flat   (bl_flat)
  );

  seg_scan_phase #(.NUM_BP(NUM_BP)) u_phase (
    .clk          (clk),
    .rst          (rst),
    .disp_en      (disp_en),
    .frame_strobe (frame_strobe),
    .duty_code    (duty_code),
    .cur_phase    (cur_phase),
    .full_duty    (full_duty),
    .bp_sel       (bp_sel)
  );

  seg_scan_column #(.NUM_FP(NUM_FP), .NUM_BP(NUM_BP)) u_column (
    .on_flat   (on_flat),
    .bl_flat   (bl_flat),
    .phase     (cur_phase),
    .blank_en  (blink_dark),
    .force_all (blink_all & plane_sel),
    .full_duty (full_duty),
    .column    (column)
  );

  // The frontplane vector is captured only at phase boundaries.
  always_ff @(posedge clk) begin
    if (rst || !disp_en) fp_on <= '0;
    else if (frame_strobe) fp_on <= column;
  end

  // R10: no change between strobes
  assert_hold_between_strobes_R10: assert property (@(posedge clk) disable iff (rst)
    (disp_en && !frame_strobe) |=> $stable(fp_on));

  // R7: shared pin never lit while it acts as a backplane
  assert_shared_pin_R7: assert property (@(posedge clk) disable iff (rst)
    bp_sel[NUM_BP-1] |-> !fp_on[NUM_FP-1]);

  // R9: blink-all dark phase blanks the whole display
  assert_blink_all_dark_R9: assert property (@(posedge clk) disable iff (rst)
    (disp_en && frame_strobe && blink_dark && blink_all && plane_sel) |=> (fp_on == '0));

endmodule

// File: tb/seg_scan_ctrl_tb.sv
module seg_scan_ctrl_tb;

  localparam int CLK_P  = 10;
  localparam int NFP    = 41;
  localparam int NBY    = 21;
  localparam int WD_CYC = 50000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        plane_sel = 1'b0;
  logic [1:0]  duty_code = 2'd3;
  logic        disp_en = 1'b0;
  logic        blink_all = 1'b0;
  logic        frame_strobe = 1'b0;
  logic        blink_dark = 1'b0;
  logic [3:0]  bp_sel;
  logic [40:0] fp_on;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] on_m [NBY];
  logic [7:0] bl_m [NBY];

  always #(CLK_P/2) clk = ~clk;

  seg_scan_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .plane_sel(plane_sel),
    .duty_code(duty_code), .disp_en(disp_en), .blink_all(blink_all),
    .frame_strobe(frame_strobe), .blink_dark(blink_dark),
    .bp_sel(bp_sel), .fp_on(fp_on)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Model write following R2 and R4.
  task automatic wr(input int a, input logic [7:0] d, input bit pl);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d; plane_sel = pl;
    @(negedge clk);
    reg_we = 1'b0;
    if (a < NBY) begin
      if (pl) bl_m[a] = (a == NBY - 1) ? (d & 8'h0F) : d;
      else    on_m[a] = (a == NBY - 1) ? (d & 8'h0F) : d;
    end
  endtask

  task automatic rd_chk(input int a, input bit pl);
    logic [7:0] e;
    @(negedge clk);
    reg_addr = 5'(a); plane_sel = pl;
    @(negedge clk);
    e = (a >= NBY) ? 8'h00 : (pl ? bl_m[a] : on_m[a]);
    chk(reg_rdata == e, (a >= NBY) ? "R4 unmapped read" : (a == NBY - 1 ? "R4 last byte" : "R2 readback"),
        64'(reg_rdata), 64'(e));
  endtask

  function automatic logic [40:0] exp_fp(int ph, int nbp, bit dark, bit force_all);
    logic [40:0] v;
    for (int f = 0; f < NFP; f++) begin
      int  b  = f / 2;
      int  bi = (f % 2) * 4 + ph;
      logic o = on_m[b][bi];
      logic e = bl_m[b][bi];
      v[f] = o & ~(dark & (e | force_all));
      if (f == NFP - 1 && nbp == 4) v[f] = 1'b0;
    end
    return v;
  endfunction

  task automatic strobe();
    @(negedge clk);
    frame_strobe = 1'b1;
    @(negedge clk);
    frame_strobe = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    disp_en = 1'b0;
    @(negedge clk);
    disp_en = 1'b1;
  endtask

  // Sweep two frames under one setting of the controls.
  task automatic sweep(input int code, input bit dark, input bit ball, input bit pl, input string req);
    int nbp = (code == 0) ? 2 : code + 1;
    duty_code = 2'(code); blink_dark = dark; blink_all = ball; plane_sel = pl;
    restart();
    for (int i = 0; i < 2 * nbp; i++) begin
      int ph = i % nbp;
      logic [40:0] e;
      strobe();
      e = exp_fp(ph, nbp, dark, ball & pl);
      chk(bp_sel == 4'(1 << ph), "R5 backplane sequence", 64'(bp_sel), 64'(1 << ph));
      chk(fp_on == e, req, 64'(fp_on), 64'(e));
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [40:0] held;
    for (int i = 0; i < NBY; i++) begin on_m[i] = '0; bl_m[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(bp_sel == 4'h0, "R1 reset bp_sel", 64'(bp_sel), 64'h0);
    chk(fp_on == '0, "R1 reset fp_on", 64'(fp_on), 64'h0);
    chk(reg_rdata == 8'h00, "R1 reset rdata", 64'(reg_rdata), 64'h0);
    rst = 1'b0;

    // R2/R4: fill both planes, including unmapped addresses.
    for (int a = 0; a < 32; a++) wr(a, 8'((a * 37 + 11) & 255), 1'b0);
    for (int a = 0; a < 32; a++) wr(a, 8'((a * 91 + 5) & 255), 1'b1);
    for (int a = 0; a < 32; a++) rd_chk(a, 1'b0);
    for (int a = 0; a < 32; a++) rd_chk(a, 1'b1);

    // R6: disabled display stays dark on strobes
    disp_en = 1'b0;
    strobe();
    chk(bp_sel == 4'h0, "R6 disabled bp_sel", 64'(bp_sel), 64'h0);
    chk(fp_on == '0, "R6 disabled fp_on", 64'(fp_on), 64'h0);

    // R3/R5/R7: all duty codes, no blinking
    for (int c = 0; c < 4; c++) sweep(c, 1'b0, 1'b0, 1'b0, "R3 R7 column map");
    sweep(3, 1'b0, 1'b1, 1'b1, "R8 bright phase follows on plane");
    // R8: per-segment blanking
    sweep(3, 1'b1, 1'b0, 1'b0, "R8 per-segment blank");
    sweep(2, 1'b1, 1'b0, 1'b1, "R8 per-segment blank 1/3");
    // R9: blink_all needs the blink plane selected
    sweep(3, 1'b1, 1'b1, 1'b0, "R9 blink_all ignored with plane_sel 0");
    sweep(1, 1'b1, 1'b1, 1'b1, "R9 blink_all blanks all");

    // R10: write between strobes is deferred
    duty_code = 2'd3; blink_dark = 1'b0; blink_all = 1'b0; plane_sel = 1'b0;
    restart();
    strobe();
    held = exp_fp(0, 4, 1'b0, 1'b0);
    wr(0, on_m[0] ^ 8'hFF, 1'b0);
    wr(1, on_m[1] ^ 8'hFF, 1'b0);
    chk(fp_on == held, "R10 mid-phase write held", 64'(fp_on), 64'(held));
    strobe();
    chk(fp_on == exp_fp(1, 4, 1'b0, 1'b0), "R10 write visible next phase",
        64'(fp_on), 64'(exp_fp(1, 4, 1'b0, 1'b0)));

    // R6: disable mid-frame, then restart at phase 0
    strobe();
    @(negedge clk);
    disp_en = 1'b0;
    @(negedge clk);
    chk(bp_sel == 4'h0, "R6 disable mid-frame", 64'(bp_sel), 64'h0);
    chk(fp_on == '0, "R6 disable mid-frame fp_on", 64'(fp_on), 64'h0);
    disp_en = 1'b1;
    strobe();
    chk(bp_sel == 4'h1, "R6 restart at phase 0", 64'(bp_sel), 64'h1);

    summary();
  end

endmodule